// File: doc/BRIEF.md
# Programmable Phase-Skew Clock Output Bank

This block is the digital output stage of a skew-programmable clock driver. It runs on a fast clock at sixteen times the nominal output frequency. A free-running phase counter advances one step per fast clock, and one step is one skew time unit. A reference waveform has its rising edge at phase 0 (mod 16) and its falling edge at phase 8. Four output pairs are derived from the counter. Each pair can lead or lag the reference by whole time units, or it can act as a divide-by-2 or divide-by-4 output, or as an inverted output.

Each bank is configured by two three-level pins. Each pin is carried as a 2-bit code: 00 is LOW, 01 is MID, 10 is HIGH, and 11 is read as MID. A polarity select moves the alignment from the reference's rising edge to its falling edge. A synchronous park request stops outputs at a defined level. A three-level test code turns any bank set to LL into a disabled bank. Banks park and unpark only at a moment when their waveform already sits at the parked level, so no shortened pulse ever appears.

Top module: `skew_clk_bank`

## Requirements
- R1: The phase counter starts at 0 after a synchronous reset and advances one step per clock, modulo 64. After the n-th clock edge that follows reset release, the outputs show the waveform of phase n-1. An undivided output has a period of 16 steps and is high for 8 of them.
- R2: Bank b is set by bank_sel[4b+3:4b+2] (first pin) and bank_sel[4b+1:4b] (second pin). Each pin is decoded as 00=LOW, 01=MID, 10=HIGH and 11=MID. The code index is 3*first+second, with LOW=0, MID=1 and HIGH=2, so index 0 is LL and index 8 is HH.
- R3: Banks 0 and 1 use offset k = index-4 time units. Their output is high while ((p - s - k) mod 16) < 8, where p is the phase and s is the polarity shift. Both outputs of a pair are always equal.
- R4: Banks 2 and 3 use offset k = 2*(index-4) for indices 1 to 7. Index 0 gives divide-by-2, which is high while ((p - s) mod 32) < 16.
- R5: Index 8 gives divide-by-4 on bank 2, which is high while ((p - s) mod 64) < 32. On bank 3, index 8 gives the complement of the zero-offset waveform.
- R6: While park_req is 1, banks 0, 1 and 3 park LOW. Bank 2 keeps running. An inverted bank 3 instead parks HIGH when edge_pos is 1 and LOW when edge_pos is 0.
- R7: The polarity shift s is 0 when edge_pos is 1 and 8 when edge_pos is 0. With edge_pos at 0, alignment therefore moves to the falling reference edge, and the divided outputs change on that edge.
- R8: When test_code decodes to MID and park_req is 1, every bank whose index is 0 (LL) parks LOW, bank 2 included. Banks with any other index keep their configured behaviour.
- R9: A bank enters or leaves the parked state only in a cycle where its running waveform equals its parked level. A bank that is not parked shows its running waveform.
- R10: A synchronous reset clears the counter, all park states and all outputs to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock, 16 steps per nominal output period |
| rst | input | 1 | Synchronous reset, active high |
| edge_pos | input | 1 | 1: align to rising reference edge; 0: align to falling edge |
| park_req | input | 1 | Synchronous park request, active high |
| test_code | input | 2 | Three-level test code (00 LOW, 01/11 MID, 10 HIGH) |
| bank_sel | input | 16 | Two three-level pins per bank, 4 bits per bank |
| q | output | 8 | Outputs; q[2b] and q[2b+1] form pair b |

## Verification
A park request and a waveform edge on the same bank can fall into the same cycle. The bench provokes this by toggling park_req, edge_pos and test_code at arbitrary phases while every bank runs. It then compares every output in every cycle against a phase model of its own, so a park that lands mid-pulse is caught at once. In the second case, the test-mode LL disable and the feedback exemption of bank 2 act on the same bank together. This is judged by the steady parked levels of bank 2 under each test code.

// File: rtl/skew_bank_pkg.sv
package skew_bank_pkg;
  localparam int PH_W   = 6;
  localparam int UNIT_W = 4;
  localparam logic [PH_W-1:0] FALL_SHIFT = PH_W'(1 << (UNIT_W - 1));

  typedef enum logic [1:0] {
    MODE_SKEW = 2'd0,
    MODE_DIV2 = 2'd1,
    MODE_DIV4 = 2'd2,
    MODE_INV  = 2'd3
  } lane_mode_e;

  typedef struct packed {
    lane_mode_e        mode;
    logic signed [4:0] offs;
  } lane_cfg_t;

  // Three-level pin: 11 folds onto MID.
  function automatic logic [1:0] tri_level(input logic [1:0] pin);
    return (pin == 2'b11) ? 2'b01 : pin;
  endfunction

  function automatic logic [3:0] code_index(input logic [1:0] f1, input logic [1:0] f0);
    return ({2'b00, tri_level(f1)} * 4'd3) + {2'b00, tri_level(f0)};
  endfunction

  // Running waveform of one lane at phase ph, with the polarity shift applied.
  function automatic logic lane_wave(input logic [PH_W-1:0] ph, input lane_cfg_t cfg,
                                     input logic [PH_W-1:0] shift);
    logic [PH_W-1:0] adj;
    logic [PH_W-1:0] rel;
    adj = ph - shift;
    rel = adj - PH_W'({{(PH_W-5){cfg.offs[4]}}, cfg.offs});
    case (cfg.mode)
      MODE_SKEW: return !rel[UNIT_W-1];
      MODE_DIV2: return !adj[UNIT_W];
      MODE_DIV4: return !adj[UNIT_W+1];
      default:   return adj[UNIT_W-1];
    endcase
  endfunction
endpackage

// File: rtl/skew_phase_ctr.sv
module skew_phase_ctr
  import skew_bank_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  output logic [PH_W-1:0] cnt
);
  always_ff @(posedge clk) begin
    if (rst) cnt <= '0;
    else     cnt <= cnt + 1'b1;
  end

  // R1: one step per clock, wrapping at the counter width
  a_r1_count_step: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> cnt == PH_W'($past(cnt) + 1'b1));
endmodule

// File: rtl/skew_cfg_decode.sv
module skew_cfg_decode
  import skew_bank_pkg::*;
#(
  parameter int KIND = 0  // 0: fine taps, 1: coarse with /4, 2: coarse with invert
) (
  input  logic [1:0] pin_a,
  input  logic [1:0] pin_b,
  output lane_cfg_t  cfg,
  output logic       code_ll
);
  logic [3:0]        idx;
  logic signed [4:0] centred;

  assign idx     = code_index(pin_a, pin_b);
  assign centred = $signed({1'b0, idx}) - 5'sd4;
  assign code_ll = (idx == 4'd0);

  generate
    if (KIND == 0) begin : g_fine
      always_comb begin
        cfg.mode = MODE_SKEW;
        cfg.offs = centred;
      end
    end else begin : g_coarse
      always_comb begin
        cfg.offs = '0;
        if (idx == 4'd0) begin
          cfg.mode = MODE_DIV2;
        end else if (idx == 4'd8) begin
          cfg.mode = (KIND == 1) ? MODE_DIV4 : MODE_INV;
        end else begin
          cfg.mode = MODE_SKEW;
          cfg.offs = centred <<< 1;
        end
      end
    end
  endgenerate
endmodule

// File: rtl/skew_lane.sv
module skew_lane
  import skew_bank_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic [PH_W-1:0] ph,
  input  logic [PH_W-1:0] shift,
  input  lane_cfg_t       cfg,
  input  logic            want_park,
  input  logic            park_lvl,
  output logic            q,
  output logic            parked
);
  logic raw;
  logic at_level;
  logic park_nxt;

  assign raw      = lane_wave(ph, cfg, shift);
  assign at_level = (raw == park_lvl);
  assign park_nxt = (want_park != parked && at_level) ? want_park : parked;

  always_ff @(posedge clk) begin
    if (rst) begin
      parked <= 1'b0;
      q      <= 1'b0;
    end else begin
      parked <= park_nxt;
      q      <= park_nxt ? park_lvl : raw;
    end
  end

  // R9: any change of park state lands on the parked level
  a_r9_switch_on_level: assert property (@(posedge clk) disable iff (rst)
    (parked != $past(parked)) |-> q == $past(park_lvl));

  // R6: a parked lane holds its parked level
  a_r6_parked_hold: assert property (@(posedge clk) disable iff (rst)
    parked |-> q == $past(park_lvl));

  // R9: a pending release completes at the next on-level cycle
  a_r9_release: assert property (@(posedge clk) disable iff (rst)
    (parked && !want_park && at_level) |=> !parked);

  // R10: reset leaves the lane cleared
  a_r10_reset_clear: assert property (@(posedge clk)
    $past(rst) |-> (!q && !parked));
endmodule

// File: rtl/skew_clk_bank.sv
module skew_clk_bank
  import skew_bank_pkg::*;
#(
  parameter int BANKS = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             edge_pos,
  input  logic             park_req,
  input  logic [1:0]       test_code,
  input  logic [4*BANKS-1:0] bank_sel,
  output logic [2*BANKS-1:0] q
);
  localparam int FEED_BANK = 2;

  logic [PH_W-1:0] ph;
  logic [PH_W-1:0] shift;
  logic            test_mid;

  assign shift    = edge_pos ? '0 : FALL_SHIFT;
  assign test_mid = (tri_level(test_code) == 2'b01);

  skew_phase_ctr i_ctr (.clk(clk), .rst(rst), .cnt(ph));

  generate
    for (genvar b = 0; b < BANKS; b++) begin : g_bank
      localparam int KIND = (b < 2) ? 0 : ((b == FEED_BANK) ? 1 : 2);
      lane_cfg_t cfg;
      logic      code_ll;
      logic      want_park;
      logic      park_lvl;
      logic      lane_q;
      logic      parked;

      skew_cfg_decode #(.KIND(KIND)) i_dec (
        .pin_a  (bank_sel[4*b+3 -: 2]),
        .pin_b  (bank_sel[4*b+1 -: 2]),
        .cfg    (cfg),
        .code_ll(code_ll)
      );

      assign want_park = park_req && ((b != FEED_BANK) || (test_mid && code_ll));
      assign park_lvl  = (cfg.mode == MODE_INV) && edge_pos;

      skew_lane i_lane (
        .clk      (clk),
        .rst      (rst),
        .ph       (ph),
        .shift    (shift),
        .cfg      (cfg),
        .want_park(want_park),
        .park_lvl (park_lvl),
        .q        (lane_q),
        .parked   (parked)
      );

      assign q[2*b]   = lane_q;
      assign q[2*b+1] = lane_q;
    end
  endgenerate
endmodule

// File: tb/test_skew_clk_bank.sv
module test_skew_clk_bank;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        edge_pos = 1'b1;
  logic        park_req = 1'b0;
  logic [1:0]  test_code = 2'b00;
  logic [15:0] bank_sel = {4{4'b0101}};
  logic [7:0]  q;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  int mcnt;
  bit mpark[4];
  bit mq[4];
  int bn;

  skew_clk_bank i_skew_clk_bank (
    .clk(clk), .rst(rst), .edge_pos(edge_pos), .park_req(park_req),
    .test_code(test_code), .bank_sel(bank_sel), .q(q)
  );

  always #5 clk = ~clk;

  function automatic int lvl(input logic [1:0] p);
    return (p == 2'b11) ? 1 : int'(p);
  endfunction

  function automatic int idx_of(input int b);
    return 3 * lvl(bank_sel[4*b+3 -: 2]) + lvl(bank_sel[4*b+1 -: 2]);
  endfunction

  function automatic bit exp_raw(input int b, input int p);
    int a, id, k;
    a  = (p - (edge_pos ? 0 : 8) + 64) % 64;
    id = idx_of(b);
    if (b < 2) begin
      k = id - 4;
      return ((a - k + 64) % 16) < 8;
    end
    if (id == 0) return (a % 32) < 16;
    if (id == 8) return (b == 2) ? (a < 32) : !((a % 16) < 8);
    k = 2 * (id - 4);
    return ((a - k + 64) % 16) < 8;
  endfunction

  function automatic bit exp_level(input int b);
    return (b == 3 && idx_of(3) == 8 && edge_pos);
  endfunction

  function automatic bit exp_want(input int b);
    return park_req && (b != 2 || (lvl(test_code) == 1 && idx_of(b) == 0));
  endfunction

  // Reference model, built from the requirement formulas
  always @(posedge clk) begin
    if (rst) begin
      mcnt <= 0;
      bn   <= 0;
      for (int b = 0; b < 4; b++) begin
        mpark[b] <= 0;
        mq[b]    <= 0;
      end
    end else begin
      for (int b = 0; b < 4; b++) begin
        bit r, pk;
        r  = exp_raw(b, mcnt);
        pk = mpark[b];
        if (exp_want(b) != pk && r == exp_level(b)) pk = exp_want(b);
        mpark[b] <= pk;
        mq[b]    <= pk ? exp_level(b) : r;
      end
      mcnt <= (mcnt + 1) % 64;
      bn   <= bn + 1;
    end
  end

  task automatic check(input string req, input int act, input int expv);
    checks++;
    if (act != expv) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d (time %0t)", req, act, expv, $time);
    end
  endtask

  task automatic cmp_all(input string req);
    for (int b = 0; b < 4; b++) begin
      check(req, q[2*b], mq[b]);
      check({req, " pair"}, q[2*b+1], q[2*b]);
    end
  endtask

  task automatic run(input int n, input string req);
    repeat (n) begin
      @(negedge clk);
      cmp_all(req);
    end
  endtask

  task automatic set_bank(input int b, input int id, input bit alt_mid);
    logic [1:0] hi, lo;
    hi = 2'(id / 3);
    lo = 2'(id % 3);
    if (alt_mid && lo == 2'b01) lo = 2'b11;
    bank_sel[4*b+3 -: 2] = hi;
    bank_sel[4*b+1 -: 2] = lo;
  endtask

  // R10, R1: reset state and the first phase after release
  task automatic t_reset();
    int highs;
    repeat (3) @(negedge clk);
    check("R10 reset outputs", int'(q), 0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 first phase all MM", int'(q), 8'hFF);
    highs = 1;
    for (int i = 1; i < 16; i++) begin
      @(negedge clk);
      highs += q[0];
    end
    check("R1 high steps per period", highs, 8);
  endtask

  // R2, R3: all nine codes on the fine banks, with rise positions
  task automatic t_fine_sweep();
    for (int id = 0; id < 9; id++) begin
      bit prev;
      int rises;
      set_bank(0, id, 1'b0);
      set_bank(1, id, 1'b1);
      run(20, "R3 fine sweep");
      prev  = q[0];
      rises = 0;
      for (int i = 0; i < 32; i++) begin
        @(negedge clk);
        cmp_all("R2 fine sweep");
        if (q[0] && !prev) begin
          rises++;
          check("R3 rise phase", (bn - 1 - (id - 4) + 64) % 16, 0);
        end
        prev = q[0];
      end
      check("R3 rises per 32 steps", rises, 2);
    end
  endtask

  // R4, R5: all nine codes on the coarse banks
  task automatic t_coarse_sweep();
    for (int id = 0; id < 9; id++) begin
      set_bank(2, id, 1'b0);
      set_bank(3, id, 1'b1);
      run(70, id == 8 ? "R5 div4 invert" : "R4 coarse sweep");
    end
  endtask

  // R7: falling-edge alignment
  task automatic t_edge();
    bit prev;
    edge_pos = 1'b0;
    set_bank(0, 6, 1'b0);
    set_bank(2, 0, 1'b0);
    set_bank(3, 8, 1'b0);
    run(40, "R7 edge low");
    prev = q[4];
    for (int i = 0; i < 64; i++) begin
      @(negedge clk);
      cmp_all("R7 edge low");
      if (q[4] && !prev) check("R7 div2 rise on falling ref", (bn - 1) % 32, 8);
      prev = q[4];
    end
    edge_pos = 1'b1;
    run(40, "R7 edge high");
  endtask

  // R6, R8, R9: park request, polarity and test code in every combination
  task automatic t_park();
    set_bank(0, 0, 1'b0);
    set_bank(1, 4, 1'b0);
    set_bank(2, 0, 1'b0);
    set_bank(3, 8, 1'b0);
    for (int pr = 0; pr < 2; pr++)
      for (int e = 0; e < 2; e++)
        for (int t = 0; t < 3; t++) begin
          park_req  = pr[0];
          edge_pos  = e[0];
          test_code = 2'(t);
          run(75, "R9 park transition");
          for (int b = 0; b < 4; b++) begin
            bit dis;
            dis = pr[0] && (b != 2 || (t == 1 && idx_of(b) == 0));
            if (dis) begin
              check(b == 3 ? "R6 invert park level" : (b == 2 ? "R8 feed bank LL" : "R6 park low"),
                    q[2*b], (b == 3 && e == 1) ? 1 : 0);
            end
          end
        end
    park_req  = 1'b0;
    test_code = 2'b00;
    set_bank(2, 4, 1'b0);
    park_req = 1'b1;
    run(40, "R6 feed bank runs");
    park_req = 1'b0;
    run(40, "R9 release");
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_fine_sweep();
    t_coarse_sweep();
    t_edge();
    t_park();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule